// File: doc/BRIEF.md
# Prefetching FIFO Read Stage

This block sits between a FIFO's storage array and its consumer, on the read-clock side. It owns the output data register, the status flag the reader watches, and the strobe that advances the read pointer. The caller latches one of two behaviours through `fwft_sel` while reset is held.

In look-ahead mode the flag means "the output register holds a fresh word". The block fetches the first word on its own once storage has held data long enough, and then keeps the register full as words are taken. In plain mode the flag means "storage holds at least one unread word". A word is copied out only when the reader asks for it.

Storage occupancy comes from a pointer comparator as a two-bit level. The level separates empty, one word and two words, and codes 3 as "three or more". A rising flag must first see storage non-empty on `SYNC_STAGES` consecutive edges. A falling flag reacts on the same edge as the read that drains storage.

Top module: `fifo_out_stage`

## Requirements
- R1: While `rst_n` is low, `dout` is 0 and `rdy_flag` is 0, and `rd_inc` stays 0 in the first cycle after reset while the level is 0.
- R2: The mode is taken from `fwft_sel` (1 = look-ahead, 0 = plain) while reset is held; changes of `fwft_sel` after reset have no effect on any output.
- R3: `mem_lvl` encodes 0 = empty, 1 = one word, 2 = two words, 3 = three or more. With the flag low, the flag rises on the edge that completes `SYNC_STAGES` (default 2) consecutive edges that all saw a non-zero level; a zero level restarts the count.
- R4: In look-ahead mode the edge that raises the flag also copies `mem_rdata` into `dout`, and `rd_inc` is 1 in the cycle before that edge.
- R5: In look-ahead mode, with the flag high, `rd_sel` high and a non-zero level, the edge loads `mem_rdata` into `dout`, `rd_inc` is 1 and the flag stays high.
- R6: In look-ahead mode, with the flag high, `rd_sel` high and level 0, the edge drops the flag, `rd_inc` is 0 and `dout` is held.
- R7: In plain mode a rising flag loads nothing: `rd_inc` is 0 and `dout` is unchanged.
- R8: In plain mode, with the flag high and `rd_sel` high, the edge loads `mem_rdata`. The flag stays high if the level is 2 or 3 and falls if it is 1.
- R9: With the flag low, `rd_sel` is ignored: `rd_inc` stays 0 (apart from the R4 prefetch) and `dout` is held.
- R10: `rd_inc` is 1 exactly in the cycles whose closing edge changes the word in `dout`; with `rd_inc` at 0, `dout` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fwft_sel | input | 1 | Mode choice, sampled during reset (1 = look-ahead) |
| rd_sel | input | 1 | Qualified read request |
| mem_rdata | input | DATA_W | Word at the current read pointer |
| mem_lvl | input | 2 | Storage level from the pointer comparator |
| dout | output | DATA_W | Output data register |
| rdy_flag | output | 1 | Output-ready (look-ahead) or not-empty (plain) flag |
| rd_inc | output | 1 | Read-pointer advance strobe, combinational |

## Verification
A wrong flag state shows up at `rdy_flag` on the next edge. A missing or extra load shows up at the same time as a `rd_inc` pulse that differs from the expected one. The mismatch also reaches `dout` within one cycle, because the reference model then points at a different storage word. A broken qualification count delays or advances the flag's rise by at least one cycle. A drop that is missed on the last read leaves the flag high while the level reads 0. Mode-latch errors show up over a whole run as prefetch-versus-no-prefetch differences on the first fill.

// File: rtl/fifo_out_stage_pkg.sv
package fifo_out_stage_pkg;
   localparam int LVL_W = 2;

   typedef enum logic [LVL_W-1:0] {
      LVL_EMPTY = 2'd0,
      LVL_ONE   = 2'd1,
      LVL_TWO   = 2'd2,
      LVL_MORE  = 2'd3
   } lvl_t;

   typedef enum logic {
      MODE_PLAIN = 1'b0,
      MODE_AHEAD = 1'b1
   } mode_t;

   function automatic logic lvl_nonempty(input lvl_t l);
      return l != LVL_EMPTY;
   endfunction

   function automatic logic lvl_two_plus(input lvl_t l);
      return (l == LVL_TWO) || (l == LVL_MORE);
   endfunction
endpackage

// File: rtl/fos_qualify.sv
module fos_qualify #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic seen,
   output logic armed
);
   localparam int HIST_W = SYNC_STAGES - 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_depth
         $error("fos_qualify: SYNC_STAGES must be at least 2");
      end

      if (HIST_W == 1) begin : g_single
         logic hist_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   hist_q <= 1'b0;
            else if (clr) hist_q <= 1'b0;
            else          hist_q <= seen;
         end
         assign armed = hist_q;
      end else begin : g_chain
         logic [HIST_W-1:0] hist_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   hist_q <= '0;
            else if (clr) hist_q <= '0;
            else          hist_q <= {hist_q[HIST_W-2:0], seen};
         end
         assign armed = &hist_q;
      end
   endgenerate
endmodule

// File: rtl/fos_flagctl.sv
module fos_flagctl
   import fifo_out_stage_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic  clk,
   input  logic  rst_n,
   input  mode_t mode,
   input  logic  rd_sel,
   input  lvl_t  lvl,
   output logic  flag,
   output logic  load
);
   logic flag_q;
   logic flag_d;
   logic ne;
   logic two_plus;
   logic armed;
   logic rise;

   assign ne       = lvl_nonempty(lvl);
   assign two_plus = lvl_two_plus(lvl);

   fos_qualify #(.SYNC_STAGES(SYNC_STAGES)) u_qual (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (flag_q),
      .seen  (ne),
      .armed (armed)
   );

   assign rise = !flag_q && ne && armed;

   always_comb begin
      flag_d = flag_q;
      load   = 1'b0;
      if (!flag_q) begin
         flag_d = rise;
         load   = rise && (mode == MODE_AHEAD);
      end else if (rd_sel) begin
         if (mode == MODE_AHEAD) begin
            load   = ne;
            flag_d = ne;
         end else begin
            load   = 1'b1;
            flag_d = two_plus;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
   end

   assign flag = flag_q;
endmodule

// File: rtl/fos_outreg.sv
module fos_outreg #(
   parameter int DATA_W = 16,
   parameter logic [DATA_W-1:0] RESET_WORD = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] q
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("fos_outreg: DATA_W must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= RESET_WORD;
      else if (load) q <= din;
   end
endmodule

// File: rtl/fifo_out_stage.sv
module fifo_out_stage
   import fifo_out_stage_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fwft_sel,
   input  logic              rd_sel,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [1:0]        mem_lvl,
   output logic [DATA_W-1:0] dout,
   output logic              rdy_flag,
   output logic              rd_inc
);
   mode_t mode_q;
   lvl_t  lvl;
   logic  load;

   assign lvl = lvl_t'(mem_lvl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= mode_t'(fwft_sel);
   end

   fos_flagctl #(.SYNC_STAGES(SYNC_STAGES)) u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode   (mode_q),
      .rd_sel (rd_sel),
      .lvl    (lvl),
      .flag   (rdy_flag),
      .load   (load)
   );

   fos_outreg #(.DATA_W(DATA_W)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .din   (mem_rdata),
      .q     (dout)
   );

   assign rd_inc = load;
endmodule

// File: rtl/fos_checker.sv
module fos_checker #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_ahead,
   input logic              rd_sel,
   input logic [DATA_W-1:0] mem_rdata,
   input logic [1:0]        mem_lvl,
   input logic [DATA_W-1:0] dout,
   input logic              rdy_flag,
   input logic              rd_inc
);
   // R10
   hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_inc |=> $stable(dout));

   // R6
   ahead_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_ahead && rdy_flag && rd_sel && mem_lvl == 2'd0) |=> (!rdy_flag && $stable(dout)));

   // R5
   ahead_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_ahead && rdy_flag && rd_sel && mem_lvl != 2'd0) |=> (rdy_flag && dout == $past(mem_rdata)));

   // R8
   plain_last_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_ahead && rdy_flag && rd_sel && mem_lvl == 2'd1) |=> !rdy_flag);

   // R7
   plain_no_prefetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_ahead && !rdy_flag) |-> !rd_inc);

   // R3
   rise_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdy_flag) |-> $past(mem_lvl) != 2'd0);
endmodule

bind fifo_out_stage fos_checker #(.DATA_W(DATA_W)) u_fos_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_ahead (mode_q == fifo_out_stage_pkg::MODE_AHEAD),
   .rd_sel     (rd_sel),
   .mem_rdata  (mem_rdata),
   .mem_lvl    (mem_lvl),
   .dout       (dout),
   .rdy_flag   (rdy_flag),
   .rd_inc     (rd_inc)
);

// File: tb/fifo_out_stage_test.sv
`timescale 1ns/1ps
module fifo_out_stage_test;
   localparam int DW = 16;
   localparam int SS = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fwft_sel = 1'b0;
   logic          rd_sel = 1'b0;
   logic [DW-1:0] mem_rdata = '0;
   logic [1:0]    mem_lvl = 2'd0;
   logic [DW-1:0] dout;
   logic          rdy_flag;
   logic          rd_inc;

   fifo_out_stage #(.DATA_W(DW), .SYNC_STAGES(SS)) uut (
      .clk(clk), .rst_n(rst_n), .fwft_sel(fwft_sel), .rd_sel(rd_sel),
      .mem_rdata(mem_rdata), .mem_lvl(mem_lvl),
      .dout(dout), .rdy_flag(rdy_flag), .rd_inc(rd_inc)
   );

   always #2.5 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [DW-1:0] mem [256];
   int            wp, rp;
   bit            m_ahead, m_flag;
   int            m_qn;
   logic [DW-1:0] m_dout;

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [1:0] lvl_of(input int cnt);
      return (cnt >= 3) ? 2'd3 : 2'(cnt);
   endfunction

   function automatic bit exp_rise(input int cnt);
      return !m_flag && (cnt != 0) && (m_qn >= SS - 1);
   endfunction

   function automatic bit exp_load(input bit rs, input int cnt);
      if (!m_flag) return exp_rise(cnt) && m_ahead;
      if (!rs) return 1'b0;
      return m_ahead ? (cnt != 0) : 1'b1;
   endfunction

   function automatic string tag_of(input bit rs, input int cnt);
      if (!m_flag) begin
         if (exp_rise(cnt)) return m_ahead ? "R4" : "R7";
         return rs ? "R9" : "R3";
      end
      if (rs) begin
         if (m_ahead) return (cnt != 0) ? "R5" : "R6";
         return "R8";
      end
      return "R10";
   endfunction

   task automatic do_reset(input bit ahead);
      @(negedge clk);
      rst_n = 1'b0; fwft_sel = ahead; rd_sel = 1'b0; mem_lvl = 2'd0;
      wp = 0; rp = 0; m_flag = 0; m_qn = 0; m_dout = '0; m_ahead = ahead;
      repeat (2) @(negedge clk);
      // R1: values while reset is held
      chk("R1", "dout in reset", dout, 0);
      chk("R1", "flag in reset", rdy_flag, 0);
      rst_n = 1'b1;
   endtask

   // one cycle: check state, drive, check strobe, clock, update model
   task automatic step(input bit rs, input bit wr, input bit flip_mode);
      int cnt;
      bit ld, rise, nf;
      string tg;
      @(negedge clk);
      cnt = wp - rp;
      tg  = flip_mode ? "R2" : "R10";
      chk(tg, "dout", dout, m_dout);
      chk(flip_mode ? "R2" : "R3", "flag", rdy_flag, m_flag);
      if (flip_mode) fwft_sel = ~m_ahead;
      rd_sel    = rs;
      mem_lvl   = lvl_of(cnt);
      mem_rdata = (cnt != 0) ? mem[rp % 256] : DW'($urandom);
      #1;
      ld   = exp_load(rs, cnt);
      rise = exp_rise(cnt);
      tg   = flip_mode ? "R2" : tag_of(rs, cnt);
      chk(tg, "rd_inc", rd_inc, ld);
      @(posedge clk);
      if (!m_flag) nf = rise;
      else if (rs) nf = m_ahead ? (cnt != 0) : (cnt >= 2);
      else nf = 1'b1;
      if (m_flag || rise) m_qn = 0;
      else m_qn = (cnt != 0) ? ((m_qn + 1 > SS - 1) ? SS - 1 : m_qn + 1) : 0;
      if (ld) begin m_dout = mem[rp % 256]; rp++; end
      m_flag = nf;
      if (wr && (wp - rp) < 200) begin mem[wp % 256] = DW'($urandom); wp++; end
   endtask

   task automatic run_random(input bit ahead, input int n, input int wr_pct, input int rd_pct, input bit flip);
      do_reset(ahead);
      for (int i = 0; i < n; i++)
         step(($urandom % 100) < rd_pct, ($urandom % 100) < wr_pct, flip);
   endtask

   initial begin
      void'($urandom(32'h5EED_0C0A));
      wp = 0; rp = 0;
      // R1: first cycle after reset with a read request on an empty store
      do_reset(1'b1);
      step(1'b1, 1'b0, 1'b0);
      chk("R1", "flag after reset", rdy_flag, 0);
      // directed look-ahead: single word, prefetch, then drain
      step(1'b0, 1'b1, 1'b0);
      step(1'b0, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b0);
      chk("R4", "prefetched word", dout, mem[0]);
      step(1'b1, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b0);
      chk("R6", "flag after drain", rdy_flag, 0);
      // directed plain: three words, no prefetch, read down
      do_reset(1'b0);
      step(1'b0, 1'b1, 1'b0);
      step(1'b0, 1'b1, 1'b0);
      step(1'b0, 1'b1, 1'b0);
      step(1'b0, 1'b0, 1'b0);
      chk("R7", "no load on rise", dout, 0);
      for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0);
      chk("R8", "flag after last read", rdy_flag, 0);
      // random phases in both modes
      run_random(1'b1, 3000, 60, 50, 1'b0);
      run_random(1'b1, 3000, 25, 80, 1'b0);
      run_random(1'b0, 3000, 60, 50, 1'b0);
      run_random(1'b0, 3000, 25, 80, 1'b0);
      // R2: mode input flipped after reset must be ignored
      run_random(1'b1, 1500, 40, 60, 1'b1);
      run_random(1'b0, 1500, 40, 60, 1'b1);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule